// File: doc/BRIEF.md
# Caption Decoder Host Register File

This block is the register file that sits behind the byte-oriented serial host port of a line-21 caption decoder. The serial framing logic in front of it hands it three kinds of already-decoded strobes: a subaddress byte, a write data byte and a read request. Subaddresses with the top bit clear select one of five write registers. These are two control bytes, an on-screen row address, an on-screen column address and an on-screen character port. Subaddresses with the top bit set select one of three read registers: a status byte and the two most recent caption bytes. Both pointers step after every access and stop at their last register.

The acquisition side pulses a strobe each time a byte pair has been captured. The block then raises a data-ready flag and drives an open-drain, active-low ready line to the host controller. Reading any register drops that flag. Reading the status byte also clears every status bit, including a flag that marks a fresh power-up. Characters written to the character port go to page memory at the current row and column, and the cursor steps after each one. A clear bit in the second control byte starts a sweep that writes a space code to every page location. When the sweep ends, the block clears that bit itself.

A stand-alone input lets three board pins replace the mode and channel bits when no host is fitted. In that case each caption mode uses a fixed character style.

Top module: `capreg_top`

## Requirements
- R1: A subaddress with bit 7 clear loads the write pointer with its low seven bits, and any value above 4 becomes 4. Each data write goes to the pointed register (0 first control, 1 second control, 2 row, 3 column, 4 character) and then advances the pointer, which holds at 4.
- R2: A subaddress with bit 7 set loads the read pointer, where low bits 0, 1 and 2 select status, first byte and second byte, and larger values select the second byte. Each read returns the selected register on `rd_data` with `rd_vld` one cycle after `rd_stb`, then advances the pointer, which holds at the second byte.
- R3: After reset both control bytes, the row and the column are zero, `dr_pull` is low, no page write is issued, and the status byte reads 0x80.
- R4: Status layout: bit 0 data ready, bit 1 parity shutdown, bit 2 extended-service bytes, bit 3 field two, bit 7 power-up, bits 6:4 zero. Reading the status byte clears all of these bits.
- R5: Any read clears data ready. An acquisition strobe in the same cycle as a read leaves data ready set.
- R6: An acquisition strobe stores both bytes for the byte registers, sets data ready and loads the field-two and extended flags from the acquisition inputs. A shutdown pulse sets bit 1.
- R7: `dr_pull` (1 = pull the ready line low) follows data ready in host mode and stays low in stand-alone mode.
- R8: A write to the character port produces one page write in the next cycle, at address row*32+column, carrying the low seven data bits. The column then advances.
- R9: Column 31 wraps to 0 and advances the row. Row 15 wraps to 0.
- R10: Writing the second control byte with bit 7 set raises `clr_busy` for exactly 512 cycles. In those cycles the block writes 0x20 to addresses 0 to 511 in rising order, then clears bit 7 and keeps bits 6:0.
- R11: A character written during the sweep produces no page write of its own, but the cursor still advances.
- R12: In host mode the effective mode is control-2 bits 1:0 (0 video, 1 text, 2 caption, 3 enhanced caption), the style is bits 3:2 and the channel is bit 6.
- R13: In stand-alone mode `sa_pins[2]` is the channel and `sa_pins[1:0]` the mode. The style is fixed at 0 (shadowed on video) for enhanced caption and at 2 for every other mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-up) |
| sub_stb | input | 1 | Subaddress byte strobe |
| sub_data | input | 8 | Subaddress byte |
| wr_stb | input | 1 | Write data strobe |
| wr_data | input | 8 | Write data byte |
| rd_stb | input | 1 | Read request strobe |
| rd_data | output | 8 | Read data, valid with rd_vld |
| rd_vld | output | 1 | Read data valid, one cycle after rd_stb |
| acq_stb | input | 1 | Byte pair captured |
| acq_b1 | input | 8 | First captured byte (bit 7 = parity error) |
| acq_b2 | input | 8 | Second captured byte (bit 7 = parity error) |
| acq_field2 | input | 1 | Captured pair came from field two |
| acq_ext | input | 1 | Captured pair is extended-service data |
| acq_shut | input | 1 | Parity shutdown event |
| sa_mode | input | 1 | Stand-alone mode select |
| sa_pins | input | 3 | Stand-alone channel and mode pins |
| dr_pull | output | 1 | Open-drain enable: pull ready line low |
| ctl0 | output | 8 | First control byte |
| ctl1 | output | 8 | Second control byte |
| eff_mode | output | 2 | Effective display mode |
| eff_style | output | 2 | Effective enhanced style |
| eff_chan | output | 1 | Effective user channel |
| pm_we | output | 1 | Page memory write enable |
| pm_addr | output | 9 | Page memory address {row, column} |
| pm_wdata | output | 7 | Page memory write data |
| clr_busy | output | 1 | Page sweep in progress |

## Verification
A wrong pointer shows up at once: the next data byte lands in the wrong control output, or the next read returns the wrong byte one cycle after the request. A status flag that was set or cleared at the wrong moment is visible on `dr_pull` in the following cycle and in the next status read. A cursor error shows on `pm_addr` one cycle after the character write, and a row-carry mistake shows only at column 31 or row 15. A sweep counter fault shows as a skipped or repeated address during the 512-cycle sweep, or as `clr_busy` and control bit 7 staying up.

// File: rtl/capreg_pkg.sv
package capreg_pkg;
   typedef enum logic [1:0] {
      MODE_VIDEO = 2'd0,
      MODE_TEXT  = 2'd1,
      MODE_CAPN  = 2'd2,
      MODE_CAPE  = 2'd3
   } disp_mode_e;

   // status bit positions, decoded by host software
   localparam int ST_RDY  = 0;
   localparam int ST_SHUT = 1;
   localparam int ST_EXT  = 2;
   localparam int ST_FLD  = 3;
   localparam int ST_POR  = 7;

   // control byte 2 fields
   localparam int C1_CHAN = 6;
   localparam int C1_CLR  = 7;

   // write register indices
   localparam int WR_CTL0 = 0;
   localparam int WR_CTL1 = 1;
   localparam int WR_ROW  = 2;
   localparam int WR_COL  = 3;
   localparam int WR_CHAR = 4;
endpackage

// File: rtl/capreg_ptr.sv
module capreg_ptr #(
   parameter int IN_W = 7,
   parameter int LAST = 4,
   localparam int W   = (LAST < 1) ? 1 : $clog2(LAST + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [IN_W-1:0] load_val,
   input  logic            step,
   output logic [W-1:0]    ptr
);
   localparam logic [W-1:0] LAST_C = W'(LAST);

   if (LAST < 1 || IN_W < W) begin : g_bad_cfg
      $error("capreg_ptr: LAST must be at least 1 and IN_W wide enough");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr <= '0;
      end else if (load) begin
         if (int'(load_val) > LAST) ptr <= LAST_C;
         else                       ptr <= W'(load_val);
      end else if (step && ptr != LAST_C) begin
         ptr <= ptr + 1'b1;
      end
   end

   // R1/R2: pointer never leaves the register range
   p_ptr_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ptr <= LAST_C);
   // R1/R2: saturation at the last register
   p_ptr_sat_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && ptr == LAST_C) |=> ptr == LAST_C);
   p_ptr_adv_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && ptr != LAST_C) |=> ptr == $past(ptr) + 1'b1);
endmodule

// File: rtl/capreg_status.sv
module capreg_status
   import capreg_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_stb,
   input  logic              rd_is_stat,
   input  logic              acq_stb,
   input  logic [BYTE_W-1:0] acq_b1,
   input  logic [BYTE_W-1:0] acq_b2,
   input  logic              acq_field2,
   input  logic              acq_ext,
   input  logic              acq_shut,
   output logic [BYTE_W-1:0] status,
   output logic [BYTE_W-1:0] byte1,
   output logic [BYTE_W-1:0] byte2,
   output logic              data_ready
);
   logic shut_q, ext_q, fld_q, por_q;
   logic rd_stat;

   if (BYTE_W != 8) begin : g_bad_cfg
      $error("capreg_status: status layout needs 8-bit bytes");
   end

   assign rd_stat = rd_stb && rd_is_stat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_ready <= 1'b0;
         shut_q     <= 1'b0;
         ext_q      <= 1'b0;
         fld_q      <= 1'b0;
         por_q      <= 1'b1;
         byte1      <= '0;
         byte2      <= '0;
      end else begin
         if (acq_stb)     data_ready <= 1'b1;
         else if (rd_stb) data_ready <= 1'b0;

         if (acq_shut)     shut_q <= 1'b1;
         else if (rd_stat) shut_q <= 1'b0;

         if (acq_stb) begin
            ext_q <= acq_ext;
            fld_q <= acq_field2;
            byte1 <= acq_b1;
            byte2 <= acq_b2;
         end else if (rd_stat) begin
            ext_q <= 1'b0;
            fld_q <= 1'b0;
         end

         if (rd_stat) por_q <= 1'b0;
      end
   end

   always_comb begin
      status          = '0;
      status[ST_RDY]  = data_ready;
      status[ST_SHUT] = shut_q;
      status[ST_EXT]  = ext_q;
      status[ST_FLD]  = fld_q;
      status[ST_POR]  = por_q;
   end

   // R5: a read without a new capture drops data ready
   p_rdy_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && !acq_stb) |=> !data_ready);
   // R6: a capture always leaves data ready set
   p_rdy_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      acq_stb |=> data_ready);
   // R4: power-up flag only falls after a status read
   p_por_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(por_q) |-> $past(rd_stat));
endmodule

// File: rtl/capreg_cursor.sv
module capreg_cursor #(
   parameter int ROW_W  = 4,
   parameter int COL_W  = 5,
   parameter int CHAR_W = 7,
   localparam int AW    = ROW_W + COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              row_ld,
   input  logic [ROW_W-1:0]  row_val,
   input  logic              col_ld,
   input  logic [COL_W-1:0]  col_val,
   input  logic              char_stb,
   input  logic [CHAR_W-1:0] char_val,
   input  logic              mem_en,
   output logic              pm_we,
   output logic [AW-1:0]     pm_addr,
   output logic [CHAR_W-1:0] pm_wdata
);
   localparam logic [COL_W-1:0] COL_MAX = '1;

   logic [ROW_W-1:0] row;
   logic [COL_W-1:0] col;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row <= '0;
         col <= '0;
      end else if (char_stb) begin
         col <= col + 1'b1;
         if (col == COL_MAX) row <= row + 1'b1;
      end else begin
         if (row_ld) row <= row_val;
         if (col_ld) col <= col_val;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pm_we    <= 1'b0;
         pm_addr  <= '0;
         pm_wdata <= '0;
      end else begin
         pm_we <= char_stb && mem_en;
         if (char_stb) begin
            pm_addr  <= {row, col};
            pm_wdata <= char_val;
         end
      end
   end

   // R8: every character steps the column by one
   p_col_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      char_stb |=> col == $past(col) + 1'b1);
   // R9: column overflow carries into the row
   p_row_carry_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (char_stb && col == COL_MAX) |=> row == $past(row) + 1'b1);
   p_row_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (char_stb && col != COL_MAX) |=> $stable(row));
endmodule

// File: rtl/capreg_sweep.sv
module capreg_sweep #(
   parameter int AW = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   output logic          busy,
   output logic          done,
   output logic [AW-1:0] addr
);
   localparam logic [AW-1:0] ADDR_MAX = '1;

   if (AW < 1) begin : g_bad_cfg
      $error("capreg_sweep: AW must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         addr <= '0;
      end else if (!busy) begin
         if (start) begin
            busy <= 1'b1;
            addr <= '0;
         end
      end else if (addr == ADDR_MAX) begin
         busy <= 1'b0;
      end else begin
         addr <= addr + 1'b1;
      end
   end

   assign done = busy && (addr == ADDR_MAX);

   // R10: the sweep visits addresses in rising order without gaps
   p_sweep_adv_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && addr != ADDR_MAX) |=> busy && addr == $past(addr) + 1'b1);
   p_sweep_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && addr == ADDR_MAX) |=> !busy);
endmodule

// File: rtl/capreg_top.sv
module capreg_top
   import capreg_pkg::*;
#(
   parameter int ROW_W                   = 4,
   parameter int COL_W                   = 5,
   parameter int CHAR_W                  = 7,
   parameter logic [CHAR_W-1:0] FILL_CODE = 7'h20,
   parameter logic [1:0] SA_ENH_STYLE    = 2'd0,
   parameter logic [1:0] SA_NRM_STYLE    = 2'd2,
   localparam int BYTE_W                 = 8,
   localparam int AW                     = ROW_W + COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sub_stb,
   input  logic [BYTE_W-1:0] sub_data,
   input  logic              wr_stb,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              rd_stb,
   output logic [BYTE_W-1:0] rd_data,
   output logic              rd_vld,
   input  logic              acq_stb,
   input  logic [BYTE_W-1:0] acq_b1,
   input  logic [BYTE_W-1:0] acq_b2,
   input  logic              acq_field2,
   input  logic              acq_ext,
   input  logic              acq_shut,
   input  logic              sa_mode,
   input  logic [2:0]        sa_pins,
   output logic              dr_pull,
   output logic [BYTE_W-1:0] ctl0,
   output logic [BYTE_W-1:0] ctl1,
   output logic [1:0]        eff_mode,
   output logic [1:0]        eff_style,
   output logic              eff_chan,
   output logic              pm_we,
   output logic [AW-1:0]     pm_addr,
   output logic [CHAR_W-1:0] pm_wdata,
   output logic              clr_busy
);
   localparam int WR_LAST = WR_CHAR;
   localparam int RD_LAST = 2;
   localparam int WP_W    = $clog2(WR_LAST + 1);
   localparam int RP_W    = $clog2(RD_LAST + 1);

   if (ROW_W < 1 || ROW_W > BYTE_W || COL_W < 1 || COL_W > BYTE_W ||
       CHAR_W < 1 || CHAR_W > BYTE_W) begin : g_bad_cfg
      $error("capreg_top: field widths must fit in one byte");
   end

   logic [WP_W-1:0]   wptr;
   logic [RP_W-1:0]   rptr;
   logic              wsub, rsub;
   logic              wr_row, wr_col, wr_chr, wr_c1;
   logic [BYTE_W-1:0] stat, b1, b2;
   logic              rdy;
   logic              sw_busy, sw_done;
   logic [AW-1:0]     sw_addr;
   logic              cu_we;
   logic [AW-1:0]     cu_addr;
   logic [CHAR_W-1:0] cu_data;

   assign wsub = sub_stb && !sub_data[BYTE_W-1];
   assign rsub = sub_stb &&  sub_data[BYTE_W-1];

   capreg_ptr #(.IN_W(BYTE_W-1), .LAST(WR_LAST)) u_wptr (
      .clk(clk), .rst_n(rst_n), .load(wsub),
      .load_val(sub_data[BYTE_W-2:0]), .step(wr_stb), .ptr(wptr));

   capreg_ptr #(.IN_W(BYTE_W-1), .LAST(RD_LAST)) u_rptr (
      .clk(clk), .rst_n(rst_n), .load(rsub),
      .load_val(sub_data[BYTE_W-2:0]), .step(rd_stb), .ptr(rptr));

   assign wr_c1  = wr_stb && (wptr == WP_W'(WR_CTL1));
   assign wr_row = wr_stb && (wptr == WP_W'(WR_ROW));
   assign wr_col = wr_stb && (wptr == WP_W'(WR_COL));
   assign wr_chr = wr_stb && (wptr == WP_W'(WR_CHAR));

   // control bytes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl0 <= '0;
         ctl1 <= '0;
      end else begin
         if (wr_stb && wptr == WP_W'(WR_CTL0)) ctl0 <= wr_data;
         if (wr_c1) ctl1[C1_CLR-1:0] <= wr_data[C1_CLR-1:0];
         if (sw_done)                ctl1[C1_CLR] <= 1'b0;
         else if (wr_c1 && !sw_busy) ctl1[C1_CLR] <= wr_data[C1_CLR];
      end
   end

   capreg_status #(.BYTE_W(BYTE_W)) u_status (
      .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb),
      .rd_is_stat(rptr == '0), .acq_stb(acq_stb),
      .acq_b1(acq_b1), .acq_b2(acq_b2), .acq_field2(acq_field2),
      .acq_ext(acq_ext), .acq_shut(acq_shut),
      .status(stat), .byte1(b1), .byte2(b2), .data_ready(rdy));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data <= '0;
         rd_vld  <= 1'b0;
      end else begin
         rd_vld <= rd_stb;
         if (rd_stb) begin
            case (rptr)
               RP_W'(0): rd_data <= stat;
               RP_W'(1): rd_data <= b1;
               default:  rd_data <= b2;
            endcase
         end
      end
   end

   capreg_cursor #(.ROW_W(ROW_W), .COL_W(COL_W), .CHAR_W(CHAR_W)) u_cursor (
      .clk(clk), .rst_n(rst_n),
      .row_ld(wr_row), .row_val(wr_data[ROW_W-1:0]),
      .col_ld(wr_col), .col_val(wr_data[COL_W-1:0]),
      .char_stb(wr_chr), .char_val(wr_data[CHAR_W-1:0]),
      .mem_en(!sw_busy),
      .pm_we(cu_we), .pm_addr(cu_addr), .pm_wdata(cu_data));

   capreg_sweep #(.AW(AW)) u_sweep (
      .clk(clk), .rst_n(rst_n),
      .start(wr_c1 && wr_data[C1_CLR]),
      .busy(sw_busy), .done(sw_done), .addr(sw_addr));

   assign clr_busy = sw_busy;
   assign pm_we    = sw_busy | cu_we;
   assign pm_addr  = sw_busy ? sw_addr   : cu_addr;
   assign pm_wdata = sw_busy ? FILL_CODE : cu_data;

   // mode source: host register or stand-alone pins
   always_comb begin
      if (sa_mode) begin
         eff_mode  = sa_pins[1:0];
         eff_chan  = sa_pins[2];
         eff_style = (sa_pins[1:0] == MODE_CAPE) ? SA_ENH_STYLE : SA_NRM_STYLE;
      end else begin
         eff_mode  = ctl1[1:0];
         eff_style = ctl1[3:2];
         eff_chan  = ctl1[C1_CHAN];
      end
   end

   assign dr_pull = rdy && !sa_mode;

   // R10: the clear bit stays set for the whole sweep
   p_busy_bit_r10: assert property (@(posedge clk) disable iff (!rst_n)
      clr_busy |-> ctl1[C1_CLR]);
   // R10: the clear bit falls only when a sweep ends
   p_clr_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ctl1[C1_CLR]) |-> $past(sw_done));
   // R2: read data follows each read request by one cycle
   p_rd_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb |=> rd_vld);
endmodule

// File: tb/test_capreg_top.sv
module test_capreg_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sub_stb = 1'b0, wr_stb = 1'b0, rd_stb = 1'b0;
   logic [7:0] sub_data = '0, wr_data = '0;
   logic [7:0] rd_data;
   logic       rd_vld;
   logic       acq_stb = 1'b0, acq_field2 = 1'b0, acq_ext = 1'b0, acq_shut = 1'b0;
   logic [7:0] acq_b1 = '0, acq_b2 = '0;
   logic       sa_mode = 1'b0;
   logic [2:0] sa_pins = '0;
   logic       dr_pull;
   logic [7:0] ctl0, ctl1;
   logic [1:0] eff_mode, eff_style;
   logic       eff_chan;
   logic       pm_we;
   logic [8:0] pm_addr;
   logic [6:0] pm_wdata;
   logic       clr_busy;

   int checks = 0;
   int errors = 0;
   bit done_flag = 1'b0;

   always #5 clk = ~clk;

   capreg_top i_capreg_top (
      .clk(clk), .rst_n(rst_n), .sub_stb(sub_stb), .sub_data(sub_data),
      .wr_stb(wr_stb), .wr_data(wr_data), .rd_stb(rd_stb), .rd_data(rd_data),
      .rd_vld(rd_vld), .acq_stb(acq_stb), .acq_b1(acq_b1), .acq_b2(acq_b2),
      .acq_field2(acq_field2), .acq_ext(acq_ext), .acq_shut(acq_shut),
      .sa_mode(sa_mode), .sa_pins(sa_pins), .dr_pull(dr_pull),
      .ctl0(ctl0), .ctl1(ctl1), .eff_mode(eff_mode), .eff_style(eff_style),
      .eff_chan(eff_chan), .pm_we(pm_we), .pm_addr(pm_addr),
      .pm_wdata(pm_wdata), .clr_busy(clr_busy));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_sub(input logic [7:0] d);
      @(negedge clk); sub_stb = 1'b1; sub_data = d;
      @(negedge clk); sub_stb = 1'b0;
   endtask

   task automatic do_wr(input logic [7:0] d);
      @(negedge clk); wr_stb = 1'b1; wr_data = d;
      @(negedge clk); wr_stb = 1'b0;
   endtask

   task automatic do_rd(output logic [7:0] v);
      @(negedge clk); rd_stb = 1'b1;
      @(negedge clk); rd_stb = 1'b0; v = rd_data;
   endtask

   task automatic do_acq(input logic [7:0] a, input logic [7:0] b,
                         input logic f2, input logic ex);
      @(negedge clk); acq_stb = 1'b1; acq_b1 = a; acq_b2 = b;
      acq_field2 = f2; acq_ext = ex;
      @(negedge clk); acq_stb = 1'b0;
   endtask

   function automatic logic [7:0] effv();
      return {3'b000, eff_chan, eff_style, eff_mode};
   endfunction

   // {op[22:20], req[19:16], data[15:8], expect[7:0]}
   // op: 0 subaddress, 1 write, 2 read+check, 3 check ctl0, 4 check ctl1, 5 check effective mode
   localparam int NV = 21;
   localparam logic [22:0] VEC [NV] = '{
      {3'd0, 4'd0,  8'h80, 8'h00},
      {3'd2, 4'd3,  8'h00, 8'h80},  // R3 power-up status
      {3'd2, 4'd2,  8'h00, 8'h00},  // R2 first byte
      {3'd2, 4'd2,  8'h00, 8'h00},  // R2 second byte
      {3'd2, 4'd2,  8'h00, 8'h00},  // R2 held at last
      {3'd0, 4'd0,  8'h80, 8'h00},
      {3'd2, 4'd4,  8'h00, 8'h00},  // R4 power-up flag cleared
      {3'd0, 4'd0,  8'h00, 8'h00},
      {3'd1, 4'd0,  8'hA5, 8'h00},
      {3'd1, 4'd0,  8'h4E, 8'h00},
      {3'd3, 4'd1,  8'h00, 8'hA5},  // R1
      {3'd4, 4'd1,  8'h00, 8'h4E},  // R1
      {3'd5, 4'd12, 8'h00, 8'h1E},  // R12
      {3'd0, 4'd0,  8'h01, 8'h00},
      {3'd1, 4'd0,  8'h0D, 8'h00},
      {3'd4, 4'd1,  8'h00, 8'h0D},  // R1
      {3'd5, 4'd12, 8'h00, 8'h0D},  // R12
      {3'd0, 4'd0,  8'h05, 8'h00},  // R1 out of range -> character port
      {3'd1, 4'd0,  8'h33, 8'h00},
      {3'd3, 4'd1,  8'h00, 8'hA5},  // R1 untouched
      {3'd4, 4'd1,  8'h00, 8'h0D}   // R1 untouched
   };

   task automatic finish_sim();
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_sim();
   end

   initial begin
      logic [7:0] v;
      int bad;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R3 reset state
      chk("R3 ctl0", ctl0, 8'h00);
      chk("R3 ctl1", ctl1, 8'h00);
      chk("R3 dr_pull", dr_pull, 1'b0);
      chk("R3 pm_we", pm_we, 1'b0);
      chk("R3 clr_busy", clr_busy, 1'b0);

      for (int i = 0; i < NV; i++) begin
         logic [2:0] op;
         logic [3:0] rq;
         logic [7:0] d, e;
         string tag;
         {op, rq, d, e} = VEC[i];
         tag = $sformatf("R%0d vector %0d", rq, i);
         case (op)
            3'd0: do_sub(d);
            3'd1: do_wr(d);
            3'd2: begin
               do_rd(v);
               chk(tag, v, e);
               chk({tag, " rd_vld"}, rd_vld, 1'b1);
            end
            3'd3: chk(tag, ctl0, e);
            3'd4: chk(tag, ctl1, e);
            default: chk(tag, effv(), e);
         endcase
      end

      // R6 capture, R7 ready line, R5 clear on any read, R4 layout
      do_acq(8'h94, 8'hAC, 1'b1, 1'b1);
      chk("R7 ready line after capture", dr_pull, 1'b1);
      do_sub(8'h81);
      do_rd(v);
      chk("R6 first byte", v, 8'h94);
      chk("R5 ready cleared by byte read", dr_pull, 1'b0);
      do_rd(v);
      chk("R6 second byte", v, 8'hAC);
      do_sub(8'h80);
      do_rd(v);
      chk("R4 status field+ext", v, 8'h0C);
      do_sub(8'h80);
      do_rd(v);
      chk("R4 status cleared by read", v, 8'h00);

      // R5 capture in the same cycle as a read
      do_acq(8'h11, 8'h22, 1'b0, 1'b0);
      do_sub(8'h80);
      @(negedge clk); rd_stb = 1'b1; acq_stb = 1'b1; acq_b1 = 8'h33; acq_b2 = 8'h44;
      @(negedge clk); rd_stb = 1'b0; acq_stb = 1'b0;
      chk("R5 status read at collision", rd_data, 8'h01);
      chk("R5 capture wins over read", dr_pull, 1'b1);
      do_sub(8'h81);
      do_rd(v);
      chk("R6 newest byte", v, 8'h33);

      // R6 shutdown flag
      @(negedge clk); acq_shut = 1'b1;
      @(negedge clk); acq_shut = 1'b0;
      do_sub(8'h80);
      do_rd(v);
      chk("R6 shutdown bit", v, 8'h02);

      // R13 stand-alone pins, R7 ready line suppressed
      do_acq(8'h01, 8'h02, 1'b0, 1'b0);
      sa_mode = 1'b1; sa_pins = 3'b111;
      @(negedge clk);
      chk("R13 enhanced ch2", effv(), 8'h13);
      chk("R7 no pull in stand-alone", dr_pull, 1'b0);
      sa_pins = 3'b010;
      @(negedge clk);
      chk("R13 normal caption ch1", effv(), 8'h0A);
      sa_pins = 3'b001;
      @(negedge clk);
      chk("R13 text ch1", effv(), 8'h09);
      sa_mode = 1'b0;
      @(negedge clk);
      chk("R12 host mode restored", effv(), 8'h0D);
      chk("R7 pull back in host mode", dr_pull, 1'b1);

      // R8 / R9 cursor
      do_sub(8'h02);
      do_wr(8'h03);
      do_wr(8'h1E);
      do_wr(8'h41);
      chk("R8 write enable", pm_we, 1'b1);
      chk("R8 address", pm_addr, 9'd126);
      chk("R8 data", pm_wdata, 7'h41);
      @(negedge clk);
      chk("R8 single write", pm_we, 1'b0);
      do_wr(8'hC2);
      chk("R8 address step", pm_addr, 9'd127);
      chk("R8 top bit dropped", pm_wdata, 7'h42);
      do_wr(8'h43);
      chk("R9 column wrap into row", pm_addr, 9'd128);
      do_sub(8'h02);
      do_wr(8'h0F);
      do_wr(8'h1F);
      do_wr(8'h44);
      chk("R9 last cell", pm_addr, 9'd511);
      do_wr(8'h45);
      chk("R9 row wrap", pm_addr, 9'd0);

      // R10 page sweep
      do_sub(8'h01);
      do_wr(8'h8D);
      bad = 0;
      for (int i = 0; i < 512; i++) begin
         if (!(clr_busy && pm_we && pm_addr == 9'(i) && pm_wdata == 7'h20)) bad++;
         @(negedge clk);
      end
      chk("R10 sweep cells", bad, 0);
      chk("R10 busy ends", clr_busy, 1'b0);
      chk("R10 clear bit self-cleared", ctl1, 8'h0D);

      // R11 character during sweep
      do_sub(8'h01);
      do_wr(8'h80);
      do_sub(8'h04);
      do_wr(8'h55);
      chk("R11 sweep owns the port", pm_wdata, 7'h20);
      bad = 0;
      while (clr_busy && bad < 1000) begin
         @(negedge clk);
         bad++;
      end
      do_wr(8'h56);
      chk("R11 cursor stepped", pm_addr, 9'd2);
      chk("R11 write after sweep", pm_wdata, 7'h56);
      chk("R10 other bits kept", ctl1, 8'h00);

      // R3 reset in mid-run
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R3 ctl0 after reset", ctl0, 8'h00);
      do_sub(8'h80);
      do_rd(v);
      chk("R3 power-up flag again", v, 8'h80);

      finish_sim();
   end
endmodule